// File: doc/BRIEF.md
# Dual Ramp-and-Count Converter Controller

This controller runs one ramp-and-count (Wilkinson) conversion that digitizes two held analog values at the same time. A single external ramp is compared against the held charge sample by one comparator and against the held fine-time sample by another. The controller releases the ramp, runs one shared binary counter on the fast conversion clock (40 MHz in the intended system), and freezes a separate copy of the count when each comparator output first rises. With the default 12-bit width a full ramp lasts about 100 µs.

A conversion starts with a one-cycle request while the block is idle. It ends when both values have been captured or the counter reaches full scale. Any channel that has not been captured by then reads full scale. The ramp is then put back into reset, a one-cycle done strobe is issued, and both results are presented as Gray codes. They stay on the outputs until the next conversion starts. Both comparator inputs are asynchronous and pass through two-flop synchronizers before edge detection.

Top module: `dual_ramp_adc_ctrl`

## Requirements
- R1: After reset the block is idle: ramp_rst_o is 1, ramp_run_o is 0, done_o is 0 and both code outputs are 0.
- R2: start_i sampled high while idle makes ramp_run_o high and ramp_rst_o low from the next cycle. The shared counter restarts from 0 at that edge and increases by one on each later edge until it reaches full scale (2^CNT_W-1).
- R3: Counting the start edge as edge 0, a comparator first sampled high on edge a (a >= 0) produces the binary result a+1, provided that capture happens by edge 2^CNT_W. The two synchronizer stages and the edge detector account for the offset.
- R4: Only the first rising edge of a comparator in a conversion is captured. Later falls and rises do not change its result.
- R5: The charge and fine-time channels are captured independently from the same counter. The time of one channel's edge does not affect the other channel's result.
- R6: A channel with no captured rising edge by the time the counter is at full scale reads 2^CNT_W-1. A comparator that is already high when the conversion starts does not count as rising.
- R7: The conversion ends on the edge where the later channel is captured, or on the edge where the counter is at full scale (edge 2^CNT_W), whichever comes first. In the following cycle done_o is high for exactly one cycle, ramp_run_o is low and ramp_rst_o is high.
- R8: Each output code is the Gray code of its binary result. Output bit i equals b[i] xor b[i+1], and the top bit equals b's top bit.
- R9: start_i is ignored while a conversion is running.
- R10: Results hold their values after done_o until the next accepted start, which clears both code outputs to 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_q_i | input | 1 | Comparator for the held charge sample (asynchronous) |
| cmp_t_i | input | 1 | Comparator for the held fine-time sample (asynchronous) |
| ramp_run_o | output | 1 | Ramp is released and counting |
| ramp_rst_o | output | 1 | Holds the external ramp at its start level |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| q_code_o | output | CNT_W | Gray-coded charge result |
| t_code_o | output | CNT_W | Gray-coded fine-time result |

## Verification
The bench uses a 6-bit counter so that every edge position can be swept. It uses three families of comparator timing:
- Mirrored edges, where the charge edge moves from the earliest position to past full scale while the fine-time edge moves the other way. These separate the two channels and show that the later edge sets the end of the conversion.
- Equal edges, which show that simultaneous captures on both channels end the conversion in a single cycle.
- One channel that never rises, which checks the full-scale value and the saturation end against a normal capture on the other channel.

Separate cases cover a comparator already high at start, a comparator that falls and rises again, and a start request in the middle of a conversion.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dra_state_e;

  // Binary to reflected Gray code; callers truncate to their width.
  function automatic logic [31:0] gray_encode(input logic [31:0] bin);
    return bin ^ (bin >> 1);
  endfunction

  // Full-scale value for a given counter width.
  function automatic logic [31:0] full_scale(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

endpackage

// File: rtl/dra_sync.sv
module dra_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dra_ramp_counter.sv
module dra_ramp_counter
  import dra_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  localparam logic [W-1:0] MAXV = W'(full_scale(W));

  logic [W-1:0] cnt_q;

  assign full_o = (cnt_q == MAXV);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (step_i && !full_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dra_edge_capture.sv
module dra_edge_capture
  import dra_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         arm_i,
  input  logic         sat_i,
  input  logic         lvl_i,
  input  logic [W-1:0] cnt_i,
  output logic         rise_o,
  output logic         valid_o,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] MAXV = W'(full_scale(W));

  logic         prev_q;
  logic         valid_q;
  logic [W-1:0] code_q;

  // A level that was already high is not an edge: prev follows lvl always.
  assign rise_o  = lvl_i & ~prev_q;
  assign valid_o = valid_q;
  assign code_o  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (clear_i) begin
        valid_q <= 1'b0;
        code_q  <= '0;
      end else if (arm_i && !valid_q) begin
        if (rise_o) begin
          code_q  <= cnt_i;
          valid_q <= 1'b1;
        end else if (sat_i) begin
          code_q  <= MAXV;
          valid_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_ramp_adc_ctrl.sv
module dual_ramp_adc_ctrl
  import dra_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_q_i,
  input  logic             cmp_t_i,
  output logic             ramp_run_o,
  output logic             ramp_rst_o,
  output logic             done_o,
  output logic [CNT_W-1:0] q_code_o,
  output logic [CNT_W-1:0] t_code_o
);
  localparam int NCH = 2;  // channel 0: charge, channel 1: fine time

  dra_state_e state_q, state_d;

  logic                       clear_w;
  logic                       run_w;
  logic [CNT_W-1:0]           cnt_w;
  logic                       full_w;
  logic [NCH-1:0]             cmp_raw;
  logic [NCH-1:0]             cmp_lvl;
  logic [NCH-1:0]             cap_rise;
  logic [NCH-1:0]             cap_valid;
  logic [NCH-1:0][CNT_W-1:0]  cap_code;
  logic [CNT_W-1:0]           bin_q_w;
  logic [CNT_W-1:0]           bin_t_w;
  logic                       all_caught_w;

  assign cmp_raw = {cmp_t_i, cmp_q_i};
  assign run_w   = (state_q == ST_RUN);
  assign clear_w = (state_q == ST_IDLE) && start_i;

  dra_ramp_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_w),
    .step_i  (run_w),
    .cnt_o   (cnt_w),
    .full_o  (full_w)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw[c]),
        .sync_o  (cmp_lvl[c])
      );
      dra_edge_capture #(.W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_w),
        .arm_i   (run_w),
        .sat_i   (full_w),
        .lvl_i   (cmp_lvl[c]),
        .cnt_i   (cnt_w),
        .rise_o  (cap_rise[c]),
        .valid_o (cap_valid[c]),
        .code_o  (cap_code[c])
      );
    end
  endgenerate

  assign bin_q_w      = cap_code[0];
  assign bin_t_w      = cap_code[1];
  assign all_caught_w = &(cap_valid | cap_rise);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (all_caught_w || full_w) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ramp_run_o = run_w;
  assign ramp_rst_o = !run_w;
  assign done_o     = (state_q == ST_DONE);
  assign q_code_o   = CNT_W'(gray_encode(32'(bin_q_w)));
  assign t_code_o   = CNT_W'(gray_encode(32'(bin_t_w)));
endmodule

// File: rtl/dual_ramp_adc_chk.sv
module dual_ramp_adc_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         ramp_run_o,
  input logic         done_o,
  input logic [W-1:0] q_code_o,
  input logic [W-1:0] t_code_o,
  input logic [W-1:0] cnt,
  input logic         at_max,
  input logic [1:0]   valid,
  input logic [W-1:0] bin_q,
  input logic [W-1:0] bin_t
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ramp_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_run_o) |-> done_o);

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_run_o) |-> $past(start_i));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && !at_max) |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_sat_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && at_max) |=> done_o);

  assert_first_only_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && valid[0]) |=> $stable(bin_q));

  assert_first_only_t_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && valid[1]) |=> $stable(bin_t));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_run_o && !start_i) |=> ($stable(q_code_o) && $stable(t_code_o)));
endmodule

bind dual_ramp_adc_ctrl dual_ramp_adc_chk #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ramp_run_o (ramp_run_o),
  .done_o     (done_o),
  .q_code_o   (q_code_o),
  .t_code_o   (t_code_o),
  .cnt        (cnt_w),
  .at_max     (full_w),
  .valid      (cap_valid),
  .bin_q      (bin_q_w),
  .bin_t      (bin_t_w)
);

// File: tb/tb_dual_ramp_adc_ctrl.sv
module tb_dual_ramp_adc_ctrl;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;
  localparam int SATE = 1 << W;   // edge index at which full scale ends the run

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         cmp_q_i = 1'b0;
  logic         cmp_t_i = 1'b0;
  logic         ramp_run_o, ramp_rst_o, done_o;
  logic [W-1:0] q_code_o, t_code_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_ramp_adc_ctrl #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_q_i    (cmp_q_i),
    .cmp_t_i    (cmp_t_i),
    .ramp_run_o (ramp_run_o),
    .ramp_rst_o (ramp_rst_o),
    .done_o     (done_o),
    .q_code_o   (q_code_o),
    .t_code_o   (t_code_o)
  );

  // Gray restated bit by bit: g[i] = b[i] ^ b[i+1], top bit copied (R8).
  function automatic int gray_of(input int b);
    int g = 0;
    for (int i = 0; i < W; i++) begin
      int hi = (i == W-1) ? 0 : ((b >> (i+1)) & 1);
      g |= (((b >> i) & 1) ^ hi) << i;
    end
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // a >= 0: comparator first sampled high on edge a; -1: never; -2: high before start.
  function automatic int latch_edge(input int a);
    if (a < 0 || a + 2 > SATE) return SATE;
    return a + 2;
  endfunction

  function automatic int exp_bin(input int a);
    if (a < 0 || a + 2 > SATE) return MAXV;
    return a + 1;
  endfunction

  task automatic run_case(input int aq, input int at, input bit q_rerise, input bit mid_start);
    int d, done_edge, done_cnt, eq, et, gq_done, gt_done;
    bit ramp_ok, clr_ok;
    d  = (latch_edge(aq) > latch_edge(at)) ? latch_edge(aq) : latch_edge(at);
    eq = gray_of(exp_bin(aq));
    et = gray_of(exp_bin(at));
    if (aq == -2) begin
      cmp_q_i = 1'b1;
      repeat (5) @(negedge clk);
    end
    if (at == -2) begin
      cmp_t_i = 1'b1;
      repeat (5) @(negedge clk);
    end
    start_i = 1'b1;
    if (aq == 0) cmp_q_i = 1'b1;
    if (at == 0) cmp_t_i = 1'b1;
    done_edge = -1; done_cnt = 0; ramp_ok = 1'b1; clr_ok = 1'b1;
    gq_done = -1; gt_done = -1;
    for (int k = 0; k <= d + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      start_i = (mid_start && k == 4);
      if (aq >= 0 && k + 1 == aq) cmp_q_i = 1'b1;
      if (q_rerise && aq >= 0 && k + 1 == aq + 3) cmp_q_i = 1'b0;
      if (q_rerise && aq >= 0 && k + 1 == aq + 6) cmp_q_i = 1'b1;
      if (at >= 0 && k + 1 == at) cmp_t_i = 1'b1;
      if (k == 0 && (q_code_o !== '0 || t_code_o !== '0)) clr_ok = 1'b0;
      if (ramp_run_o !== (k < d) || ramp_rst_o !== (k >= d)) ramp_ok = 1'b0;
      if (done_o === 1'b1) begin
        done_cnt++;
        if (done_edge < 0) done_edge = k;
        gq_done = int'(q_code_o);
        gt_done = int'(t_code_o);
      end
    end
    check(ramp_ok, "R2 R7 ramp control", int'(ramp_run_o), 0);
    check(done_edge == d && done_cnt == 1, "R7 done edge", done_edge, d);
    check(gq_done == eq, "R3 R4 R6 R8 charge code", gq_done, eq);
    check(gt_done == et, "R3 R5 R6 R8 time code", gt_done, et);
    check(int'(q_code_o) == eq && int'(t_code_o) == et, "R10 hold after done",
          int'(q_code_o), eq);
    check(clr_ok, "R10 clear on start", 0, 0);
    cmp_q_i = 1'b0;
    cmp_t_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ramp_rst_o === 1'b1 && ramp_run_o === 1'b0 && done_o === 1'b0,
          "R1 idle controls", int'(ramp_run_o), 0);
    check(q_code_o === '0 && t_code_o === '0, "R1 codes zero", int'(q_code_o), 0);

    // Mirrored sweep (R3, R5, R6, R7)
    for (int a = 0; a <= SATE + 1; a++)
      run_case(a, (MAXV - a >= 0) ? MAXV - a : -1, 1'b0, 1'b0);
    // Equal edges (R5, R7)
    for (int a = 0; a <= SATE; a++)
      run_case(a, a, 1'b0, 1'b0);
    // One channel never rises (R6)
    for (int a = 0; a <= SATE; a += 3) begin
      run_case(a, -1, 1'b0, 1'b0);
      run_case(-1, a, 1'b0, 1'b0);
    end
    // Both silent: saturation end (R6)
    run_case(-1, -1, 1'b0, 1'b0);
    // Level already high at start is not an edge (R6)
    run_case(-2, 10, 1'b0, 1'b0);
    run_case(20, -2, 1'b0, 1'b0);
    // Only the first rise counts (R4)
    run_case(5, 40, 1'b1, 1'b0);
    run_case(0, 30, 1'b1, 1'b0);
    // Start during conversion ignored (R9)
    run_case(12, 33, 1'b0, 1'b1);
    run_case(-1, 50, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule